// File: doc/BRIEF.md
# Descriptor-Chained Transmit DMA Sequencer

This block moves outgoing frame data from memory to a MAC transmitter. It follows a linked sequence of four-word descriptors that lie one after another in memory. Software arms it by pulsing a start request while the transmitter is enabled. From then on the engine runs without help: it reads a descriptor, streams the buffer that descriptor names as a byte stream with frame marks, clears the descriptor's ownership bit in memory, and moves on to the next descriptor. It halts when it reads a descriptor that it does not own.

A buffer either continues a frame or closes it. A continuation descriptor is handed back to software as soon as its bytes have left. A closing descriptor is handed back only after the MAC reports that the whole frame has gone out, and the status the MAC supplies is written into it at the same time. Software polls the request flag to learn that the chain has drained.

Top module: `txdma_chain`

## Requirements
- R1: A pulse on `req_set` while `tx_en` is 1 and the engine is idle sets `req_busy` and starts processing. A pulse while `tx_en` is 0 is ignored: `req_busy` stays 0 and no memory access occurs.
- R2: The first start after reset fetches its first descriptor at `list_base`. Every later fetch reads the descriptor 16 bytes after the one just written back. Word n of a descriptor is at byte offset 4n, and `mem_addr` is the byte address shifted right by 2.
- R3: Descriptor word 0 holds the owned bit (31), the wrap bit (30), the position field (29:28) and an 8-bit status field (7:0). Word 1 holds the byte count in bits 31:16. Word 2 holds the byte address of the buffer.
- R4: Exactly the byte count is streamed, starting at the buffer byte address, at any alignment. Byte k of a memory word is bits 8k+7:8k.
- R5: When bit 28 of the position field is 0 (values 00 and 10), the descriptor is a continuation. Its word 0 is written back with bit 31 cleared and all other bits unchanged, without waiting for `mac_done`.
- R6: When bit 28 of the position field is 1 (values 01 and 11), the descriptor closes a frame. Its word 0 is written back only after a `mac_done` pulse. Bit 31 is cleared and bits 7:0 are replaced by `mac_status` as sampled with that pulse.
- R7: Reading a descriptor whose owned bit is 0 clears `req_busy` and stops the engine. The next start refetches that same descriptor.
- R8: When the wrap bit is set in a written-back descriptor, the next fetch goes to `list_base`.
- R9: `tx_sof` marks the first byte streamed after a frame-closing descriptor, and the first byte after reset. `tx_eof` marks the last byte of a frame-closing buffer.
- R10: While `tx_valid` is 1 and `tx_ready` is 0, `tx_data`, `tx_sof` and `tx_eof` hold their values.
- R11: A zero-length buffer streams no bytes and is still written back according to its position field.
- R12: A memory request holds its address, direction and write data until `mem_ack`.
- R13: After reset `req_busy`, `mem_req` and `tx_valid` are 0. While `req_busy` is 0 there is no memory or stream activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tx_en | input | 1 | Transmitter enable |
| req_set | input | 1 | Start request pulse |
| list_base | input | AW | Byte address of the first descriptor |
| req_busy | output | 1 | Request flag; drops when the chain stops |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW-2 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access accepted this cycle |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | MAC accepts byte |
| tx_data | output | 8 | Stream byte |
| tx_sof | output | 1 | First byte of frame |
| tx_eof | output | 1 | Last byte of frame |
| mac_done | input | 1 | Frame transmitted pulse |
| mac_status | input | SW | Status for the finished frame |

## Verification
A wrong fetch pointer shows up at the next descriptor. Write-backs would land at unexpected addresses, or bytes from the wrong buffer would reach the MAC. A stale byte pointer or byte count corrupts the stream within the same buffer, and the byte-by-byte scoreboard catches it at the first bad byte. A lost start-of-frame flag corrupts the marks on the next frame's first byte. A write-back ordering fault shows up at the write itself, because the count of completed frames recorded at that moment is wrong. Both an early release of a closing descriptor and a delayed release of a continuation descriptor are caught this way.

// File: rtl/txdma_chain.sv
module txdma_chain #(
  parameter int AW = 16,
  parameter int LW = 16,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  logic          req_set,
  input  logic [AW-1:0] list_base,
  output logic          req_busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-3:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ack,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_sof,
  output logic          tx_eof,
  input  logic          mac_done,
  input  logic [SW-1:0] mac_status
);
  typedef enum logic [2:0] {IDLE, FD0, FD1, FD2, RD, TX, WAITM, WB} st_t;

  st_t           st, after;
  logic [AW-1:0] cur, ptr, byte_a;
  logic [LW-1:0] len;
  logic [31:0]   w0, word;
  logic          started, sof_pend;

  assign after = w0[28] ? WAITM : WB;

  always_comb begin
    case (st)
      FD0:     byte_a = cur;
      FD1:     byte_a = cur + AW'(4);
      FD2:     byte_a = cur + AW'(8);
      RD:      byte_a = ptr;
      WB:      byte_a = cur;
      default: byte_a = '0;
    endcase
  end

  assign mem_addr  = byte_a[AW-1:2];
  assign mem_req   = (st == FD0) || (st == FD1) || (st == FD2) || (st == WB) ||
                     (st == RD && len != '0);
  assign mem_we    = (st == WB);
  assign mem_wdata = {1'b0, w0[30:0]};
  assign tx_valid  = (st == TX);
  assign tx_data   = word[{ptr[1:0], 3'b000} +: 8];
  assign tx_sof    = tx_valid && sof_pend;
  assign tx_eof    = tx_valid && w0[28] && (len == LW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= IDLE;
      req_busy <= 1'b0;
      started  <= 1'b0;
      sof_pend <= 1'b1;
      cur      <= '0;
      ptr      <= '0;
      len      <= '0;
      w0       <= '0;
      word     <= '0;
    end else begin
      case (st)
        IDLE: if (req_set && tx_en) begin
          req_busy <= 1'b1;
          st       <= FD0;
          if (!started) begin
            cur     <= list_base;
            started <= 1'b1;
          end
        end
        FD0: if (mem_ack) begin
          w0 <= mem_rdata;
          if (mem_rdata[31]) st <= FD1;
          else begin
            req_busy <= 1'b0;
            st       <= IDLE;
          end
        end
        FD1: if (mem_ack) begin
          len <= mem_rdata[31:32-LW];
          st  <= FD2;
        end
        FD2: if (mem_ack) begin
          ptr <= mem_rdata[AW-1:0];
          st  <= RD;
        end
        RD: begin
          if (len == '0) st <= after;
          else if (mem_ack) begin
            word <= mem_rdata;
            st   <= TX;
          end
        end
        TX: if (tx_ready) begin
          ptr      <= ptr + AW'(1);
          len      <= len - LW'(1);
          sof_pend <= 1'b0;
          if (len == LW'(1)) st <= after;
          else if (ptr[1:0] == 2'd3) st <= RD;
        end
        WAITM: if (mac_done) begin
          w0[SW-1:0] <= mac_status;
          st         <= WB;
        end
        WB: if (mem_ack) begin
          cur <= w0[30] ? list_base : cur + AW'(16);
          if (w0[28]) sof_pend <= 1'b1;
          st <= FD0;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module txdma_chain_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_en,
  input logic          req_set,
  input logic          req_busy,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-3:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          mem_ack,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          tx_sof,
  input logic          tx_eof
);
  // R10
  stream_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_sof) && $stable(tx_eof));
  // R12
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  // R1
  start_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_busy) |-> $past(req_set && tx_en));
  // R13
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_busy |-> !mem_req && !tx_valid);
  // R1
  start_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_busy && !tx_en |=> !mem_req);
endmodule

bind txdma_chain txdma_chain_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_txdma_chain.sv
module tb_txdma_chain;
  localparam int AW = 16;
  localparam int SW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tx_en = 1'b0;
  logic          req_set = 1'b0;
  logic [AW-1:0] list_base = 16'h0100;
  logic          req_busy, mem_req, mem_we, mem_ack;
  logic [AW-3:0] mem_addr;
  logic [31:0]   mem_wdata, mem_rdata;
  logic          tx_valid, tx_ready, tx_sof, tx_eof;
  logic [7:0]    tx_data;
  logic          mac_done = 1'b0;
  logic [SW-1:0] mac_status = '0;

  always #4 clk = ~clk;

  txdma_chain #(.AW(AW), .SW(SW)) dut (.*);

  logic [31:0] mem [0:1023];
  logic [15:0] lfsr;
  int checks = 0, errors = 0;
  int done_cnt = 0, ends = 0, mac_cd = 0, stray_req = 0;
  bit sof_next = 1'b1;
  logic [9:0]  byte_q [$];
  logic [55:0] wb_q [$];

  assign mem_ack   = mem_req && (lfsr[5] || lfsr[9]);
  assign tx_ready  = lfsr[0] || lfsr[3];
  assign mem_rdata = mem[mem_addr[9:0]];

  always @(posedge clk) begin
    if (!rst_n) lfsr <= 16'hACE1;
    else lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (mem_req && mem_we && mem_ack) mem[mem_addr[9:0]] <= mem_wdata;
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mbyte(int b);
    return mem[(b >> 2) & 1023][8*(b & 3) +: 8];
  endfunction

  task automatic put_desc(int a, bit act, bit wrap, bit [1:0] fp, int ln, int bufa);
    logic [31:0] w0, wb;
    w0 = {act, wrap, fp, 20'h0C3A1, 8'h5A};
    mem[(a >> 2) & 1023]       = w0;
    mem[((a >> 2) + 1) & 1023] = {ln[15:0], 16'hBEEF};
    mem[((a >> 2) + 2) & 1023] = bufa;
    mem[((a >> 2) + 3) & 1023] = 32'hDEAD_0000;
    if (act) begin
      for (int i = 0; i < ln; i++)
        byte_q.push_back({sof_next && i == 0, fp[0] && i == ln - 1, mbyte(bufa + i)});
      if (ln > 0) sof_next = 1'b0;
      if (fp[0]) begin
        ends++;
        sof_next = 1'b1;
        wb = {1'b0, wrap, fp, 20'h0C3A1, 8'(ends)};
      end else wb = {1'b0, w0[30:0]};
      wb_q.push_back({16'(a), wb, 8'(ends)});
    end
  endtask

  task automatic start();
    @(negedge clk) req_set = 1'b1;
    @(negedge clk) req_set = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (req_busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // monitor: stream bytes, write-backs, MAC model
  always @(negedge clk) begin
    if (rst_n) begin
      logic [9:0]  eb;
      logic [55:0] ew;
      if (!tx_en && mem_req) stray_req++;
      if (tx_valid && tx_ready) begin
        if (byte_q.size() == 0) check(0, "R4 unexpected byte", tx_data, 0);
        else begin
          eb = byte_q.pop_front();
          // R4 R9
          check({tx_sof, tx_eof, tx_data} == eb, "R4 R9 byte/marks", {tx_sof, tx_eof, tx_data}, eb);
        end
        if (tx_eof) mac_cd = 3;
      end
      if (mem_req && mem_we && mem_ack) begin
        if (wb_q.size() == 0) check(0, "R5 R6 unexpected write", mem_wdata, 0);
        else begin
          ew = wb_q.pop_front();
          // R2 R8: address; R5 R6: data and timing relative to mac_done
          check({mem_addr, 2'b00} == ew[55:40], "R2 R8 write-back address", {mem_addr, 2'b00}, ew[55:40]);
          check(mem_wdata == ew[39:8], "R3 R5 R6 write-back data", mem_wdata, ew[39:8]);
          check(done_cnt == int'(ew[7:0]), "R5 R6 write-back order", done_cnt, ew[7:0]);
        end
      end
      mac_done <= 1'b0;
      if (mac_cd == 1) begin
        done_cnt++;
        mac_done   <= 1'b1;
        mac_status <= SW'(done_cnt);
      end
      if (mac_cd > 0) mac_cd--;
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int w = 0; w < 1024; w++)
      mem[w] = {8'(w) ^ 8'h11, 8'(w) + 8'd3, ~8'(w), 8'(w)};
    repeat (3) @(negedge clk);
    // R13
    check(!req_busy && !mem_req && !tx_valid, "R13 reset state", {req_busy, mem_req, tx_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: start ignored when disabled
    start();
    repeat (20) @(negedge clk);
    check(!req_busy && stray_req == 0, "R1 start while disabled", {req_busy, 8'(stray_req)}, 0);

    // run 1: continuation, unaligned closing buffers, stop on unowned
    put_desc(16'h100, 1, 0, 2'b10, 5, 16'h400);
    put_desc(16'h110, 1, 0, 2'b01, 6, 16'h502);
    put_desc(16'h120, 1, 0, 2'b11, 3, 16'h603);
    put_desc(16'h130, 0, 0, 2'b00, 4, 16'h700);
    tx_en = 1'b1;
    start();
    repeat (2) @(negedge clk);
    check(req_busy, "R1 request flag set", req_busy, 1);
    wait_idle();
    // R7
    check(!req_busy && byte_q.size() == 0 && wb_q.size() == 0, "R7 stop on unowned (run 1)",
          {req_busy, 8'(byte_q.size()), 8'(wb_q.size())}, 0);

    // run 2: refetch of 0x130, zero-length continuation, wrap to base
    put_desc(16'h130, 1, 0, 2'b00, 0, 16'h700);
    put_desc(16'h140, 1, 1, 2'b01, 4, 16'h6F1);
    start();
    wait_idle();
    // R7 R8 R11
    check(!req_busy && byte_q.size() == 0 && wb_q.size() == 0, "R7 R8 R11 run 2 drained",
          {req_busy, 8'(byte_q.size()), 8'(wb_q.size())}, 0);
    check(mem[16'h130 >> 2][31] == 1'b0, "R11 zero-length released", mem[16'h130 >> 2], 0);

    // run 3: wrap left pointer at base; 0x100 now owned again
    put_desc(16'h100, 1, 0, 2'b01, 2, 16'h400);
    start();
    wait_idle();
    check(!req_busy && byte_q.size() == 0 && wb_q.size() == 0, "R8 R2 run 3 from base",
          {req_busy, 8'(byte_q.size()), 8'(wb_q.size())}, 0);
    check(done_cnt == ends, "R6 frames completed", done_cnt, ends);

    // R1: disabled again, start ignored
    tx_en = 1'b0;
    put_desc(16'h110, 1, 0, 2'b01, 2, 16'h400);
    byte_q.delete();
    wb_q.delete();
    start();
    repeat (20) @(negedge clk);
    check(!req_busy && !tx_valid && stray_req == 0, "R1 R13 start ignored after disable",
          {req_busy, tx_valid, 8'(stray_req)}, 0);
    check(mem[16'h110 >> 2][31] == 1'b1, "R1 descriptor untouched", mem[16'h110 >> 2][31], 1);
    finish_run();
  end
endmodule